// File: doc/BRIEF.md
# Shift-Chain Output Error Classifier

This block exercises a set of parallel flip-flop shift chains and sorts the errors seen at their outputs by how long they last. A stimulus register toggles on every clock, so it produces a square wave at half the clock rate. The square wave leaves the block on `stim_o`. The test fixture routes it back through whatever path is under study and returns it on `chain_din_i`, one bit per chain. Each chain is a run of flip-flops. A chain flagged as inverting adds one inversion at its entry. One reference delay line of the same depth carries the clean stimulus. Each chain output is compared with the reference after that chain's polarity has been applied to it.

Every chain has its own tracker, which counts how many samples in a row have mismatched. When the run ends, the tracker decides what kind of event it was. A run of exactly one sample is an upset. A run of two up to one short of the interrupt threshold is a long upset. A run that reaches the threshold is counted as a functional interrupt at the moment it reaches it. Each chain has three saturating counters for these event kinds. Any counter can be read through a combinational address port. A synchronous clear wipes all counters and all trackers together.

Top module: `shift_chain_classifier`

## Requirements
- R1: After reset `stim_o` is 0, and it inverts on every rising clock edge.
- R2: A value that differs from the stimulus on `chain_din_i[c]` at edge k produces exactly one mismatched sample for chain c, CHAIN_DEPTH edges later.
- R3: A run of exactly one mismatched sample that is closed by a correct sample adds 1 to that chain's upset counter, read with class code 0.
- R4: A run of 2 to RUN_LIMIT-1 mismatched samples adds 1 to the long-upset counter (class code 1) when the first correct sample closes it. It adds nothing to the upset counter.
- R5: A run that reaches RUN_LIMIT (default 50) samples adds 1 to the interrupt counter (class code 2). It adds nothing more however long it continues, and it never counts as a long upset.
- R6: Each chain's tracker and counters change only in response to that chain's own samples.
- R7: Counters are CNT_W bits wide (default 16). They hold at their all-ones value instead of wrapping.
- R8: While `clr_i` is high at a clock edge, every counter and run tracker is 0 after that edge. A run in progress restarts from zero.
- R9: `rd_addr_i` = {chain index, class code[1:0]} selects the value returned on `rd_data_o`. Class code 3, or a chain index of NUM_CHAINS or more, returns 0.
- R10: Chains whose bit is set in INV_MASK invert their input. With the loopback clean, they produce no events, just like the non-inverting chains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for chains, reference and trackers |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all counters and run trackers |
| chain_din_i | input | NUM_CHAINS | Returned stimulus, one bit per chain entry |
| stim_o | output | 1 | Square-wave stimulus at half the clock rate |
| rd_addr_i | input | CH_W+2 | Counter select: chain index in the upper bits, class code in bits 1:0 |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
The bench probes the run-length boundaries at 1, 2, 49, 50 and more than 50 samples. A tracker that is off by one would put the 49-sample run in the interrupt counter, or the 2-sample run in the upset counter. A tracker that still closes a run after it has reached the threshold would add a long upset on top of the interrupt. A clear is issued in the middle of a 60-sample run. A design that clears the counters but not the tracker would then report an interrupt rather than one long upset. The bench drives a long train of lone errors to push a narrowed counter past its maximum, where a wrapping counter would read back a small value. It also fires bursts on two chains in the same cycles, so any leakage between neighbouring chains would show up.

// File: rtl/sce_pkg.sv
package sce_pkg;

  // Class codes; these are also the low two bits of the read address.
  typedef enum logic [1:0] {
    EV_UPSET = 2'd0,
    EV_LONG  = 2'd1,
    EV_INTR  = 2'd2,
    EV_NONE  = 2'd3
  } ev_cls_e;

  // Class of a run that a correct sample has just closed.
  function automatic ev_cls_e close_class(input int unsigned run_len,
                                          input int unsigned limit);
    if (run_len == 1)                        return EV_UPSET;
    else if (run_len >= 2 && run_len < limit) return EV_LONG;
    else                                     return EV_NONE;
  endfunction

endpackage

// File: rtl/sce_delay_line.sv
module sce_delay_line #(
  parameter int   DEPTH = 8,
  parameter logic INIT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= INIT;
        else        sr <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {DEPTH{INIT}};
        else        sr <= {sr[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/sce_run_classifier.sv
module sce_run_classifier
  import sce_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RUN_LIMIT = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mis,
  output logic [CNT_W-1:0] cnt_upset,
  output logic [CNT_W-1:0] cnt_long,
  output logic [CNT_W-1:0] cnt_intr
);

  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam logic [RUN_W-1:0] LIM   = RUN_W'(RUN_LIMIT);
  localparam logic [CNT_W-1:0] CMAX  = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic en);
    return (en && v != CMAX) ? v + 1'b1 : v;
  endfunction

  function automatic logic [RUN_W-1:0] run_next(input logic [RUN_W-1:0] r,
                                                input logic m);
    if (!m)       return '0;
    else if (r == LIM) return r;
    else          return r + 1'b1;
  endfunction

  logic [RUN_W-1:0] run_q;
  ev_cls_e          close_cls;
  logic             ev_upset, ev_long, ev_intr;

  assign close_cls = close_class(32'(run_q), RUN_LIMIT);
  assign ev_upset  = !mis && (close_cls == EV_UPSET);
  assign ev_long   = !mis && (close_cls == EV_LONG);
  assign ev_intr   = mis && (run_q == LIM - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      cnt_upset <= '0;
      cnt_long  <= '0;
      cnt_intr  <= '0;
    end else if (clr) begin
      run_q     <= '0;
      cnt_upset <= '0;
      cnt_long  <= '0;
      cnt_intr  <= '0;
    end else begin
      run_q     <= run_next(run_q, mis);
      cnt_upset <= sat_inc(cnt_upset, ev_upset);
      cnt_long  <= sat_inc(cnt_long, ev_long);
      cnt_intr  <= sat_inc(cnt_intr, ev_intr);
    end
  end

  // R8: clear empties tracker and counters on the next edge
  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (run_q == '0 && cnt_upset == '0 && cnt_long == '0 && cnt_intr == '0));

  // R3: a correct sample closes the run
  assert_run_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !mis) |=> run_q == '0);

  // R5: run grows one per mismatched sample until the limit
  assert_run_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mis && run_q != LIM) |=> run_q == $past(run_q) + 1'b1);

  // R5: a run at the limit never adds a long upset nor a second interrupt
  assert_intr_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && run_q == LIM) |=> ($stable(cnt_intr) && $stable(cnt_long)));

  // R3: a lone mismatch closing raises the upset count unless saturated
  assert_lone_upset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !mis && run_q == 1 && cnt_upset != CMAX) |=> cnt_upset == $past(cnt_upset) + 1'b1);

  // R7: saturated counters stay at the maximum
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (cnt_upset == CMAX || cnt_long == CMAX || cnt_intr == CMAX)) |=>
      (($past(cnt_upset) != CMAX || cnt_upset == CMAX) &&
       ($past(cnt_long)  != CMAX || cnt_long  == CMAX) &&
       ($past(cnt_intr)  != CMAX || cnt_intr  == CMAX)));

endmodule

// File: rtl/shift_chain_classifier.sv
module shift_chain_classifier
  import sce_pkg::*;
#(
  parameter int NUM_CHAINS  = 9,
  parameter int CHAIN_DEPTH = 8,
  parameter int CNT_W       = 16,
  parameter int RUN_LIMIT   = 50,
  parameter logic [NUM_CHAINS-1:0] INV_MASK = NUM_CHAINS'(9'b1_0000_0100),
  localparam int CH_W   = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic [NUM_CHAINS-1:0] chain_din_i,
  output logic                  stim_o,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [CNT_W-1:0]      rd_data_o
);

  logic                  stim_q;
  logic                  ref_q;
  logic [NUM_CHAINS-1:0] chain_q;
  logic [NUM_CHAINS-1:0] mis;
  logic [CNT_W-1:0]      cnt_up   [NUM_CHAINS];
  logic [CNT_W-1:0]      cnt_lg   [NUM_CHAINS];
  logic [CNT_W-1:0]      cnt_in   [NUM_CHAINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stim_q <= 1'b0;
    else        stim_q <= ~stim_q;
  end
  assign stim_o = stim_q;

  sce_delay_line #(.DEPTH(CHAIN_DEPTH), .INIT(1'b0)) u_ref (
    .clk(clk), .rst_n(rst_n), .d(stim_q), .q(ref_q)
  );

  generate
    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
      sce_delay_line #(.DEPTH(CHAIN_DEPTH), .INIT(INV_MASK[c])) u_chain (
        .clk(clk), .rst_n(rst_n), .d(chain_din_i[c] ^ INV_MASK[c]), .q(chain_q[c])
      );
      assign mis[c] = chain_q[c] ^ (ref_q ^ INV_MASK[c]);

      sce_run_classifier #(.CNT_W(CNT_W), .RUN_LIMIT(RUN_LIMIT)) u_cls (
        .clk(clk), .rst_n(rst_n), .clr(clr_i), .mis(mis[c]),
        .cnt_upset(cnt_up[c]), .cnt_long(cnt_lg[c]), .cnt_intr(cnt_in[c])
      );
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CHAINS; i++) begin
      if (rd_addr_i[ADDR_W-1:2] == CH_W'(i)) begin
        case (ev_cls_e'(rd_addr_i[1:0]))
          EV_UPSET: rd_data_o = cnt_up[i];
          EV_LONG:  rd_data_o = cnt_lg[i];
          EV_INTR:  rd_data_o = cnt_in[i];
          default:  rd_data_o = '0;
        endcase
      end
    end
  end

  // R1: stimulus inverts on every edge out of reset
  assert_stim_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stim_q != $past(stim_q));

  // R9: class code 3 always reads zero
  assert_unused_class_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i[1:0] == 2'd3) |-> rd_data_o == '0);

endmodule

// File: tb/shift_chain_classifier_tb_top.sv
module shift_chain_classifier_tb_top;

  localparam int NCH    = 9;
  localparam int DEPTH  = 8;
  localparam int CW     = 8;
  localparam int LIMIT  = 50;
  localparam int AW     = 6;
  localparam int CMAXV  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic [NCH-1:0] flip = '0;
  logic [NCH-1:0] din;
  logic          stim;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  assign din = {NCH{stim}} ^ flip;

  shift_chain_classifier #(.NUM_CHAINS(NCH), .CHAIN_DEPTH(DEPTH), .CNT_W(CW),
                           .RUN_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .chain_din_i(din),
    .stim_o(stim), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  bit m_pipe [NCH][$];
  int m_run  [NCH];
  int m_cnt  [NCH][3];
  bit m_stim = 1'b0;

  initial begin
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < DEPTH; k++) m_pipe[c].push_back(1'b0);
      m_run[c] = 0;
      for (int k = 0; k < 3; k++) m_cnt[c][k] = 0;
    end
  end

  function automatic void bump(int c, int k);
    if (m_cnt[c][k] < CMAXV) m_cnt[c][k]++;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_stim = !m_stim;
      for (int c = 0; c < NCH; c++) begin
        bit m;
        m = m_pipe[c].pop_front();
        m_pipe[c].push_back(flip[c]);
        if (clr) begin
          m_run[c] = 0;
          for (int k = 0; k < 3; k++) m_cnt[c][k] = 0;
        end else if (m) begin
          if (m_run[c] < LIMIT) begin
            m_run[c]++;
            if (m_run[c] == LIMIT) bump(c, 2);
          end
        end else begin
          if (m_run[c] == 1) bump(c, 0);
          else if (m_run[c] >= 2 && m_run[c] < LIMIT) bump(c, 1);
          m_run[c] = 0;
        end
      end
    end
  end

  function automatic int model_read(int a);
    int c, k;
    c = a >> 2;
    k = a & 3;
    if (c >= NCH || k == 3) return 0;
    return m_cnt[c][k];
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic step();
    string tag;
    @(negedge clk);
    cyc++;
    check("R1 stimulus", int'(stim), int'(m_stim));
    case (rd_addr[1:0])
      2'd0: tag = "R3 upset count";
      2'd1: tag = "R4 long count";
      2'd2: tag = "R5 interrupt count";
      default: tag = "R9 unused class";
    endcase
    check(tag, int'(rd_data), model_read(int'(rd_addr)));
    rd_addr = rd_addr + 1'b1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic expect_cnt(int c, int k, int exp, string tag);
    logic [AW-1:0] saved;
    saved = rd_addr;
    rd_addr = AW'((c << 2) | k);
    #1;
    check(tag, int'(rd_data), exp);
    rd_addr = saved;
  endtask

  task automatic burst(int c, int len);
    flip[c] = 1'b1;
    steps(len);
    flip[c] = 1'b0;
    steps(DEPTH + 4);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    steps(3);
    check("R1 reset stim", int'(stim), 0);
    expect_cnt(0, 0, 0, "R3 reset upset");
    rst_n = 1'b1;

    steps(20);
    // R10: inverted chains 2 and 8 idle without events
    expect_cnt(2, 0, 0, "R10 inverted chain upset");
    expect_cnt(8, 1, 0, "R10 inverted chain long");
    expect_cnt(8, 2, 0, "R10 inverted chain interrupt");

    // R2, R3: one bad sample on chain 0
    burst(0, 1);
    expect_cnt(0, 0, 1, "R3 lone upset");
    expect_cnt(0, 1, 0, "R3 lone not long");

    // R2: latency check, error must not surface before DEPTH edges
    flip[3] = 1'b1;
    step();
    flip[3] = 1'b0;
    steps(DEPTH - 1);
    expect_cnt(3, 0, 0, "R2 before latency");
    steps(2);
    expect_cnt(3, 0, 1, "R2 after latency");

    // R4: runs of 5 and 2
    burst(1, 5);
    expect_cnt(1, 1, 1, "R4 run of five");
    expect_cnt(1, 0, 0, "R4 run of five not upset");
    burst(2, 2);
    expect_cnt(2, 1, 1, "R4 run of two");
    expect_cnt(2, 0, 0, "R4 run of two not upset");

    // R5: 49 stays long, 50 and 120 become interrupts
    burst(4, LIMIT - 1);
    expect_cnt(4, 1, 1, "R5 run 49 long");
    expect_cnt(4, 2, 0, "R5 run 49 no interrupt");
    burst(5, LIMIT);
    expect_cnt(5, 2, 1, "R5 run 50 interrupt");
    expect_cnt(5, 1, 0, "R5 run 50 not long");
    burst(8, 120);
    expect_cnt(8, 2, 1, "R5 run 120 single interrupt");
    expect_cnt(8, 1, 0, "R5 run 120 not long");

    // R6: simultaneous bursts on neighbours
    flip[6] = 1'b1;
    flip[7] = 1'b1;
    step();
    flip[6] = 1'b0;
    steps(2);
    flip[7] = 1'b0;
    steps(DEPTH + 4);
    expect_cnt(6, 0, 1, "R6 chain 6 upset");
    expect_cnt(6, 1, 0, "R6 chain 6 no long");
    expect_cnt(7, 1, 1, "R6 chain 7 long");
    expect_cnt(7, 0, 0, "R6 chain 7 no upset");

    // R8: clear in the middle of a 60-sample run on chain 3
    flip[3] = 1'b1;
    steps(30);
    clr = 1'b1;
    step();
    clr = 1'b0;
    expect_cnt(5, 2, 0, "R8 interrupt cleared");
    expect_cnt(0, 0, 0, "R8 upset cleared");
    steps(29);
    flip[3] = 1'b0;
    steps(DEPTH + 4);
    expect_cnt(3, 1, 1, "R8 restarted run long");
    expect_cnt(3, 2, 0, "R8 restarted run no interrupt");

    // R7: saturate chain 0 upset counter
    for (int i = 0; i < CMAXV + 5; i++) begin
      flip[0] = 1'b1;
      step();
      flip[0] = 1'b0;
      step();
    end
    steps(DEPTH + 4);
    expect_cnt(0, 0, CMAXV, "R7 saturated upset");
    expect_cnt(0, 1, 0, "R7 alternating not long");

    // R9: unused class and out-of-range chains read zero
    expect_cnt(0, 3, 0, "R9 class 3");
    expect_cnt(9, 0, 0, "R9 chain 9");
    expect_cnt(15, 2, 0, "R9 chain 15");

    steps(70);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule